// File: doc/BRIEF.md
# 64-bit Comparator Global Timer

This block is a free-running 64-bit up-counter with a programmable prescaler. A 64-bit comparator raises a sticky event flag once the count has reached it. Software reaches every register as a 32-bit word over a small register bus with an address, a write strobe, write data and combinational read data. The 64-bit count and the 64-bit comparator are each split into a low word and a high word, and software reads them with two separate accesses.

A 32-bit step register gives periodic interrupts. When auto-increment is on, each match adds the step to the comparator, so the next event falls a fixed number of ticks later. The interrupt output follows the event flag while the interrupt enable is set. Software clears the flag by writing a one to it.

Top module: `gtimer_cmp64`

## Requirements
- R1: After reset every register (count, control, status, comparator, step) reads zero and `irq` is low. Unmapped addresses read zero.
- R2: While the run bit is set, the count advances by one every (prescaler + 1) clocks, counted from the edge that sets the run bit. While the run bit is clear, the count holds its value.
- R3: The count low word is at byte address 0x00 and the high word is at 0x04. A carry out of the low word increments the high word.
- R4: Writes to either count word take effect only while the run bit is clear. While the timer runs they are ignored.
- R5: The control word is at 0x08 with these fields: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-increment, bits 15:8 prescaler. It reads back these fields, and all other bits read zero.
- R6: While compare enable is set and the 64-bit count is greater than or equal to the 64-bit comparator, the event flag (bit 0 of the status word at 0x0C) is set on the next clock. With compare enable clear, no event is raised.
- R7: `irq` is high exactly when the event flag and the interrupt enable are both set.
- R8: The event flag stays set until a write to 0x0C with bit 0 set. A write with bit 0 clear has no effect.
- R9: When a clearing write and a match occur in the same cycle, the flag stays set.
- R10: With auto-increment on, each matching cycle adds the step register (0x18) to the comparator. With it off, the comparator keeps its value.
- R11: The comparator low word is at 0x10, the high word at 0x14 and the step at 0x18. Each reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit prescaler and a 5-bit byte address. With these values, a prescaler of 2 shows the divided count rate, and a prescaler of 255 holds the count still long enough to test that writes are locked out while it runs. Because the count can be written while the timer is stopped, the bench preloads it just below a 32-bit boundary to test the low-to-high carry, and it uses the comparator's high word to test the 64-bit compare without waiting 2^32 cycles.

// File: rtl/gtimer_cmp64.sv
module gtimer_cmp64 #(
  parameter int PRESC_W = 8,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'('h18);

  logic [63:0]        cnt_q, cmp_q;
  logic [31:0]        step_q;
  logic [PRESC_W-1:0] presc_q, div_q;
  logic               run_q, cmp_en_q, irq_en_q, auto_q, flag_q;

  wire wr_cnt_lo = bus_we && bus_addr == A_CNT_LO;
  wire wr_cnt_hi = bus_we && bus_addr == A_CNT_HI;
  wire wr_ctl    = bus_we && bus_addr == A_CTL;
  wire wr_clr    = bus_we && bus_addr == A_STAT && bus_wdata[0];
  wire wr_cmp_lo = bus_we && bus_addr == A_CMP_LO;
  wire wr_cmp_hi = bus_we && bus_addr == A_CMP_HI;
  wire wr_step   = bus_we && bus_addr == A_STEP;

  wire tick  = run_q && (div_q == presc_q);
  wire match = cmp_en_q && (cnt_q >= cmp_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (!run_q || tick)   div_q <= '0;
    else                       div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cnt_q <= '0;
    else if (!run_q && wr_cnt_lo) cnt_q[31:0]  <= bus_wdata;
    else if (!run_q && wr_cnt_hi) cnt_q[63:32] <= bus_wdata;
    else if (tick)                cnt_q <= cnt_q + 64'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0; cmp_en_q <= 1'b0; irq_en_q <= 1'b0; auto_q <= 1'b0;
      presc_q <= '0;
    end else if (wr_ctl) begin
      run_q    <= bus_wdata[0];
      cmp_en_q <= bus_wdata[1];
      irq_en_q <= bus_wdata[2];
      auto_q   <= bus_wdata[3];
      presc_q  <= bus_wdata[8 +: PRESC_W];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cmp_q <= '0;
    else if (wr_cmp_lo)      cmp_q[31:0]  <= bus_wdata;
    else if (wr_cmp_hi)      cmp_q[63:32] <= bus_wdata;
    else if (match && auto_q) cmp_q <= cmp_q + {32'd0, step_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       step_q <= '0;
    else if (wr_step) step_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      flag_q <= 1'b0;
    else if (match)  flag_q <= 1'b1;
    else if (wr_clr) flag_q <= 1'b0;

  assign irq = flag_q && irq_en_q;

  wire [31:0] ctl_rd = (32'(presc_q) << 8) | {28'd0, auto_q, irq_en_q, cmp_en_q, run_q};

  always_comb
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[31:0];
      A_CNT_HI: bus_rdata = cnt_q[63:32];
      A_CTL:    bus_rdata = ctl_rd;
      A_STAT:   bus_rdata = {31'd0, flag_q};
      A_CMP_LO: bus_rdata = cmp_q[31:0];
      A_CMP_HI: bus_rdata = cmp_q[63:32];
      A_STEP:   bus_rdata = step_q;
      default:  bus_rdata = 32'd0;
    endcase
endmodule

module gtimer_cmp64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        auto,
  input logic        match,
  input logic        flag,
  input logic        clr,
  input logic        cnt_wr,
  input logic        cmp_wr,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] step
);
  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> cnt == $past(cnt));
  // R4
  run_only_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1));
  // R6
  flag_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R9
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R10
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto && !cmp_wr) |=> cmp == $past(cmp) + {32'd0, $past(step)});
endmodule

bind gtimer_cmp64 gtimer_cmp64_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .auto(auto_q), .match(match),
  .flag(flag_q), .clr(wr_clr), .cnt_wr(wr_cnt_lo || wr_cnt_hi),
  .cmp_wr(wr_cmp_lo || wr_cmp_hi), .cnt(cnt_q), .cmp(cmp_q), .step(step_q)
);

// File: tb/tb_gtimer_cmp64.sv
`timescale 1ns/1ps
module tb_gtimer_cmp64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  gtimer_cmp64 dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d); chk("R1", d, 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_ctl;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFF6);
    rd(5'h08, d); chk("R5", d, 32'h0000_FF06);
    wr(5'h08, 32'd0);
    wr(5'h0C, 32'd1);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(5'h00, 0); wr(5'h04, 0);
    wr(5'h08, 32'h0000_0201);
    cyc(9);  rd(5'h00, d); chk("R2 presc 2", d, 32'd3);
    cyc(1);  rd(5'h00, d); chk("R2 presc 2", d, 32'd3);
    cyc(2);  rd(5'h00, d); chk("R2 presc 2", d, 32'd4);
    wr(5'h08, 0);
    cyc(5);  rd(5'h00, d); chk("R2 hold", d, 32'd4);
  endtask

  task automatic t_carry;
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFFE); wr(5'h04, 32'd5);
    wr(5'h08, 32'd1);
    cyc(3);
    rd(5'h00, d); chk("R3 lo", d, 32'd1);
    rd(5'h04, d); chk("R3 hi", d, 32'd6);
    wr(5'h08, 0);
  endtask

  task automatic t_wrlock;
    logic [31:0] d;
    wr(5'h00, 0); wr(5'h04, 0);
    wr(5'h08, 32'h0000_FF01);
    wr(5'h00, 32'h0000_ABCD);
    rd(5'h00, d); chk("R4 lo ignored", d, 32'd0);
    wr(5'h04, 32'd7);
    rd(5'h04, d); chk("R4 hi ignored", d, 32'd0);
    wr(5'h08, 0);
    wr(5'h00, 32'h0000_ABCD);
    rd(5'h00, d); chk("R4 stopped write", d, 32'h0000_ABCD);
  endtask

  task automatic t_match;
    logic [31:0] d;
    wr(5'h0C, 1);
    wr(5'h00, 100); wr(5'h04, 0);
    wr(5'h10, 100); wr(5'h14, 0); wr(5'h18, 32'h55);
    rd(5'h10, d); chk("R11 cmp lo", d, 32'd100);
    rd(5'h18, d); chk("R11 step", d, 32'h55);
    cyc(3); rd(5'h0C, d); chk("R6 cmp off", d, 32'd0);
    wr(5'h08, 32'd2);
    rd(5'h0C, d); chk("R6 not yet", d, 32'd0);
    cyc(1); rd(5'h0C, d); chk("R6 equal", d, 32'd1);
    wr(5'h08, 0); wr(5'h0C, 1);
    wr(5'h14, 1);
    rd(5'h14, d); chk("R11 cmp hi", d, 32'd1);
    wr(5'h08, 32'd2);
    cyc(3); rd(5'h0C, d); chk("R6 high word", d, 32'd0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(5'h14, 0);
    cyc(1);
    wr(5'h08, 0);
    cyc(3); rd(5'h0C, d); chk("R8 sticky", d, 32'd1);
    chk("R7 masked", {31'd0, irq}, 32'd0);
    wr(5'h08, 32'd4);
    chk("R7 raised", {31'd0, irq}, 32'd1);
    wr(5'h0C, 0);
    rd(5'h0C, d); chk("R8 write0", d, 32'd1);
    wr(5'h0C, 1);
    rd(5'h0C, d); chk("R8 clear", d, 32'd0);
    chk("R7 dropped", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(5'h08, 32'd6);
    cyc(2);
    wr(5'h0C, 1);
    rd(5'h0C, d); chk("R9 match wins", d, 32'd1);
    wr(5'h08, 0); wr(5'h0C, 1);
    rd(5'h0C, d); chk("R8 clear", d, 32'd0);
  endtask

  task automatic t_auto;
    logic [31:0] d;
    wr(5'h00, 25); wr(5'h04, 0);
    wr(5'h10, 10); wr(5'h14, 0); wr(5'h18, 10);
    wr(5'h08, 32'hA);
    cyc(5); rd(5'h10, d); chk("R10 auto", d, 32'd30);
    rd(5'h14, d); chk("R10 auto hi", d, 32'd0);
    wr(5'h08, 0); wr(5'h0C, 1);
    wr(5'h10, 10);
    wr(5'h08, 32'd2);
    cyc(4); rd(5'h10, d); chk("R10 no auto", d, 32'd10);
    wr(5'h08, 0);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset; t_ctl; t_count; t_carry; t_wrlock;
    t_match; t_sticky; t_race; t_auto;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule